// File: doc/BRIEF.md
# Half-Duplex Modem Control Sequencer

This block is the terminal-side control logic of a half-duplex FSK modem. It times the delay from a request to send until clear to send. It qualifies a raw carrier-detect input with separate on and off delays. After the local transmitter releases the line, it holds received data at mark for a squelch interval. It also forces received data to mark whenever that data cannot be trusted.

All delays count a slow tick derived from the master clock. A mode input picks the V.23-style set, which has a two-bit select, or the Bell-style set, which uses only select bit 0. One select code sets every internal delay at once. The reserved code routes clear to send and carrier detect to external timer inputs instead. A digital loopback mode routes the terminal signals back onto themselves for test.

All terminal-side control signals are active low. Data uses 1 for mark and 0 for space. The analog energy detector and the modulator are outside the block. The block sees the detector as `cd_raw_ni` and the demodulated bit as `demod_i`. It drives `tx_key_o` and `tx_data_o` towards the modulator.

Top module: `hdx_ctrl_seq`

## Requirements
- R1: While reset is applied and just after it is released, `cts_no`=1, `cd_no`=1 and `rxd_o`=1 (mark).
- R2: One tick occurs every TICK_DIV clocks (default 4096). A delay of d ms lasts round(d×0.8739) ticks. With internal timers and no loopback, `cts_no` falls a delay after `rts_ni` falls. The delay is 200 ms for V.23 select 0, 30 ms for select 1, 70 ms for select 2, and 180 ms for Bell with select bit 0 = 0.
- R3: With internal timers and no loopback, `cts_no` returns to 1 one clock after `rts_ni` returns to 1.
- R4: `cd_no` falls only after `cd_raw_ni` has stayed low for 10 ms. It rises only after `cd_raw_ni` has stayed high for 5 ms. A raw change shorter than the delay restarts the count and leaves `cd_no` unchanged.
- R5: When `rts_ni` returns to 1 in two-wire mode (`four_wire_i`=0) with internal timers, received data is squelched. The squelch lasts 150 ms for V.23 selects 0 and 1, 40 ms for V.23 select 2, and 156 ms for Bell. With `four_wire_i`=1 no squelch occurs.
- R6: Outside loopback, `rxd_o` is 1 in three cases: `cd_no`=1, or `four_wire_i`=0 with `rts_ni`=0, or squelch active. Otherwise `rxd_o` equals `demod_i`.
- R7: External timers are selected by V.23 select 3 or by Bell select bit 0 = 1. Then `cts_no` follows `ext_cts_ni`, `cd_no` follows `ext_cd_ni`, and no squelch is applied.
- R8: With `loop_i`=1: `rxd_o`=`txd_i`, `cts_no`=`rts_ni`, `tx_key_o`=NOT `rts2_ni` and `tx_data_o`=`demod_i`.
- R9: With `loop_i`=0: `tx_key_o`=NOT `rts_ni` and `tx_data_o`=`txd_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bell_mode_i | input | 1 | 1 selects the Bell delay set, 0 selects the V.23 set |
| tsel_i | input | 2 | Timer select; Bell uses bit 0 only |
| four_wire_i | input | 1 | 1 = four-wire line, squelch and transmit blanking off |
| loop_i | input | 1 | Digital loopback enable |
| rts_ni | input | 1 | Request to send, active low |
| rts2_ni | input | 1 | Secondary request, keys carrier in loopback |
| txd_i | input | 1 | Transmit data from terminal |
| demod_i | input | 1 | Demodulated receive data |
| cd_raw_ni | input | 1 | Unqualified carrier energy detect, active low |
| ext_cts_ni | input | 1 | External clear-to-send timer result |
| ext_cd_ni | input | 1 | External carrier-detect timer result |
| cts_no | output | 1 | Clear to send, active low |
| cd_no | output | 1 | Qualified carrier detect, active low |
| rxd_o | output | 1 | Received data to terminal, 1 = mark |
| tx_key_o | output | 1 | Carrier enable to modulator |
| tx_data_o | output | 1 | Data to modulator |

## Verification
A small tick divider keeps every delay short. The request timer and the squelch timer are swept over all four internal selects. Each delay is checked at one tick before its nominal end and one tick after it. This tells the values of neighbouring selects apart and exposes an off-by-one count. The carrier qualifier is driven with a long low level, a long high level and a short glitch. These separate the on delay, the off delay and the restart behaviour. Four-wire, external-timer and loopback patterns show which of the data-forcing and routing paths each mode turns off.

// File: rtl/hdx_pkg.sv
package hdx_pkg;
  localparam int CNT_W = 10;
  typedef logic [CNT_W-1:0] dly_t;

  // ticks = round(ms * 0.8739)
  function automatic dly_t ms2tk(input int ms);
    return dly_t'((ms * 8739 + 5000) / 10000);
  endfunction

  typedef struct packed {
    dly_t rc;
    dly_t sq;
    dly_t cd_on;
    dly_t cd_off;
    logic ext;
  } dly_set_t;
endpackage

// File: rtl/hdx_tick_gen.sv
module hdx_tick_gen #(
  parameter int DIV = 4096
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic tick_o
);
  localparam int W = (DIV > 2) ? $clog2(DIV) : 1;
  localparam logic [W-1:0] LAST = W'(DIV - 1);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)           cnt_q <= '0;
    else if (cnt_q == LAST) cnt_q <= '0;
    else                   cnt_q <= cnt_q + 1'b1;
  end

  assign tick_o = (cnt_q == LAST);
endmodule

// File: rtl/hdx_delay_sel.sv
module hdx_delay_sel
  import hdx_pkg::*;
(
  input  logic       bell_i,
  input  logic [1:0] tsel_i,
  output dly_set_t   set_o
);
  always_comb begin
    set_o.cd_on  = ms2tk(10);
    set_o.cd_off = ms2tk(5);
    set_o.ext    = 1'b0;
    set_o.rc     = ms2tk(200);
    set_o.sq     = ms2tk(150);
    if (bell_i) begin
      set_o.rc  = ms2tk(180);
      set_o.sq  = ms2tk(156);
      set_o.ext = tsel_i[0];
    end else begin
      unique case (tsel_i)
        2'd0: ;
        2'd1: set_o.rc = ms2tk(30);
        2'd2: begin set_o.rc = ms2tk(70); set_o.sq = ms2tk(40); end
        default: set_o.ext = 1'b1;
      endcase
    end
  end
endmodule

// File: rtl/hdx_rts_timer.sv
module hdx_rts_timer
  import hdx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic rts_act_i,
  input  logic ext_i,
  input  logic four_wire_i,
  input  dly_t rc_ld_i,
  input  dly_t sq_ld_i,
  output logic cts_on_o,
  output logic sq_on_o
);
  logic rts_q;
  dly_t rc_cnt_q, sq_cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rts_q    <= 1'b0;
      cts_on_o <= 1'b0;
      rc_cnt_q <= '0;
    end else begin
      rts_q <= rts_act_i;
      if (!rts_act_i) begin
        cts_on_o <= 1'b0;
        rc_cnt_q <= rc_ld_i;
      end else if (!cts_on_o && tick_i) begin
        if (rc_cnt_q <= dly_t'(1)) cts_on_o <= 1'b1;
        else                       rc_cnt_q <= rc_cnt_q - 1'b1;
      end
    end
  end

  // squelch starts on release of the request
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sq_on_o  <= 1'b0;
      sq_cnt_q <= '0;
    end else if (rts_act_i) begin
      sq_on_o  <= 1'b0;
      sq_cnt_q <= sq_ld_i;
    end else if (rts_q && !four_wire_i && !ext_i) begin
      sq_on_o  <= 1'b1;
      sq_cnt_q <= sq_ld_i;
    end else if (sq_on_o && tick_i) begin
      if (sq_cnt_q <= dly_t'(1)) sq_on_o  <= 1'b0;
      else                       sq_cnt_q <= sq_cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/hdx_cd_qual.sv
module hdx_cd_qual
  import hdx_pkg::*;
(
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic raw_on_i,
  input  dly_t on_ld_i,
  input  dly_t off_ld_i,
  output logic cd_on_o
);
  dly_t cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cd_on_o <= 1'b0;
      cnt_q   <= '0;
    end else if (raw_on_i == cd_on_o) begin
      cnt_q <= cd_on_o ? off_ld_i : on_ld_i;
    end else if (tick_i) begin
      if (cnt_q <= dly_t'(1)) begin
        cd_on_o <= raw_on_i;
        cnt_q   <= raw_on_i ? off_ld_i : on_ld_i;
      end else begin
        cnt_q <= cnt_q - 1'b1;
      end
    end
  end
endmodule

// File: rtl/hdx_ctrl_seq.sv
module hdx_ctrl_seq
  import hdx_pkg::*;
#(
  parameter int TICK_DIV = 4096
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       bell_mode_i,
  input  logic [1:0] tsel_i,
  input  logic       four_wire_i,
  input  logic       loop_i,
  input  logic       rts_ni,
  input  logic       rts2_ni,
  input  logic       txd_i,
  input  logic       demod_i,
  input  logic       cd_raw_ni,
  input  logic       ext_cts_ni,
  input  logic       ext_cd_ni,
  output logic       cts_no,
  output logic       cd_no,
  output logic       rxd_o,
  output logic       tx_key_o,
  output logic       tx_data_o
);
  logic     tick, cts_on, sq_on, cd_q, cd_act, rts_act, force_mark;
  dly_set_t dset;

  assign rts_act = ~rts_ni;

  hdx_tick_gen #(.DIV(TICK_DIV)) u_tick (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_o(tick)
  );

  hdx_delay_sel u_sel (
    .bell_i(bell_mode_i), .tsel_i(tsel_i), .set_o(dset)
  );

  hdx_rts_timer u_rts (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .rts_act_i(rts_act),
    .ext_i(dset.ext), .four_wire_i(four_wire_i),
    .rc_ld_i(dset.rc), .sq_ld_i(dset.sq),
    .cts_on_o(cts_on), .sq_on_o(sq_on)
  );

  hdx_cd_qual u_cd (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .raw_on_i(~cd_raw_ni),
    .on_ld_i(dset.cd_on), .off_ld_i(dset.cd_off), .cd_on_o(cd_q)
  );

  assign cd_act     = dset.ext ? ~ext_cd_ni : cd_q;
  assign force_mark = ~cd_act | (~four_wire_i & rts_act) | sq_on;

  always_comb begin
    cd_no = ~cd_act;
    if (loop_i) begin
      cts_no    = rts_ni;
      rxd_o     = txd_i;
      tx_key_o  = ~rts2_ni;
      tx_data_o = demod_i;
    end else begin
      cts_no    = dset.ext ? ext_cts_ni : ~cts_on;
      rxd_o     = force_mark | demod_i;
      tx_key_o  = rts_act;
      tx_data_o = txd_i;
    end
  end
endmodule

// File: rtl/hdx_ctrl_seq_chk.sv
module hdx_ctrl_seq_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       bell_mode_i,
  input logic [1:0] tsel_i,
  input logic       four_wire_i,
  input logic       loop_i,
  input logic       rts_ni,
  input logic       cd_raw_ni,
  input logic       cts_no,
  input logic       cd_no,
  input logic       rxd_o
);
  logic ext_sel, cfg_stable;
  assign ext_sel = bell_mode_i ? tsel_i[0] : (tsel_i == 2'b11);

  always_ff @(posedge clk_i or negedge rst_ni)
    if (!rst_ni) cfg_stable <= 1'b0;
    else         cfg_stable <= 1'b1;

  // R3: request held off for two samples keeps clear-to-send off
  a_r3_cts_off: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_stable && !loop_i && !ext_sel && $stable(tsel_i) && $stable(bell_mode_i)
     && $stable(loop_i) && $past(rts_ni) && rts_ni) |-> cts_no);

  // R6: no carrier means mark
  a_r6_mark_no_cd: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loop_i && cd_no) |-> rxd_o);

  // R6: two-wire transmit blanks receive
  a_r6_mark_tx: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!loop_i && !four_wire_i && !rts_ni) |-> rxd_o);

  // R4: qualified detect only turns on after raw detect was on
  a_r4_cd_needs_raw: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cfg_stable && !ext_sel && $stable(tsel_i) && $stable(bell_mode_i)
     && $fell(cd_no)) |-> $past(!cd_raw_ni));
endmodule

bind hdx_ctrl_seq hdx_ctrl_seq_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .bell_mode_i(bell_mode_i), .tsel_i(tsel_i),
  .four_wire_i(four_wire_i), .loop_i(loop_i), .rts_ni(rts_ni),
  .cd_raw_ni(cd_raw_ni), .cts_no(cts_no), .cd_no(cd_no), .rxd_o(rxd_o)
);

// File: tb/hdx_ctrl_seq_tb.sv
`timescale 1ns/1ps
module hdx_ctrl_seq_tb_top;
  localparam int DIV = 4;

  logic clk = 1'b0, rst_ni = 1'b0;
  logic bell = 1'b0, four_wire = 1'b0, loop_en = 1'b0;
  logic [1:0] tsel = 2'd0;
  logic rts_n = 1'b1, rts2_n = 1'b1, txd = 1'b0, demod = 1'b0;
  logic cd_raw_n = 1'b1, ext_cts_n = 1'b1, ext_cd_n = 1'b1;
  logic cts_n, cd_n, rxd, tx_key, tx_data;
  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  hdx_ctrl_seq #(.TICK_DIV(DIV)) dut_i (
    .clk_i(clk), .rst_ni(rst_ni), .bell_mode_i(bell), .tsel_i(tsel),
    .four_wire_i(four_wire), .loop_i(loop_en), .rts_ni(rts_n), .rts2_ni(rts2_n),
    .txd_i(txd), .demod_i(demod), .cd_raw_ni(cd_raw_n),
    .ext_cts_ni(ext_cts_n), .ext_cd_ni(ext_cd_n),
    .cts_no(cts_n), .cd_no(cd_n), .rxd_o(rxd), .tx_key_o(tx_key), .tx_data_o(tx_data)
  );

  function automatic int tk(input int ms);
    return (ms * 8739 + 5000) / 10000;
  endfunction

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s act=%0b exp=%0b", tag, act, exp);
    end
  endtask

  task automatic summary;
    $display("  %0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  initial begin
    repeat (60000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog act=running exp=done");
    summary();
  end

  initial begin
    int rc_ms[4]  = '{200, 30, 70, 180};
    int sq_ms[4]  = '{150, 150, 40, 156};
    cyc(3);
    chk(cts_n, 1'b1, "R1 cts");
    chk(cd_n,  1'b1, "R1 cd");
    chk(rxd,   1'b1, "R1 rxd");
    rst_ni = 1'b1;
    cyc(1);
    chk(cts_n, 1'b1, "R1 cts after release");
    chk(rxd,   1'b1, "R1 rxd after release");

    // R9 normal routing
    txd = 1'b1; cyc(1);
    chk(tx_data, 1'b1, "R9 tx_data");
    chk(tx_key,  1'b0, "R9 tx_key idle");
    txd = 1'b0; cyc(1);
    chk(tx_data, 1'b0, "R9 tx_data low");

    // R4 carrier on delay
    cd_raw_n = 1'b0;
    cyc((tk(10) - 1) * DIV);
    chk(cd_n, 1'b1, "R4 cd early");
    cyc(DIV + 1);
    chk(cd_n, 1'b0, "R4 cd on");
    chk(rxd, 1'b0, "R6 data passes space");
    demod = 1'b1; cyc(1);
    chk(rxd, 1'b1, "R6 data passes mark");
    demod = 1'b0; cyc(1);

    // R2 / R3 / R5 sweep over internal selects
    for (int s = 0; s < 4; s++) begin
      bell = (s == 3);
      tsel = (s == 3) ? 2'd0 : 2'(s);
      cyc(2);
      rts_n = 1'b0;
      cyc(1);
      chk(tx_key, 1'b1, "R9 tx_key keyed");
      cyc((tk(rc_ms[s]) - 1) * DIV - 1);
      chk(cts_n, 1'b1, $sformatf("R2 cts early sel%0d", s));
      chk(rxd, 1'b1, "R6 mark during transmit");
      cyc(DIV + 1);
      chk(cts_n, 1'b0, $sformatf("R2 cts on sel%0d", s));
      rts_n = 1'b1;
      cyc(1);
      chk(cts_n, 1'b1, "R3 cts drop");
      cyc((tk(sq_ms[s]) - 1) * DIV);
      chk(rxd, 1'b1, $sformatf("R5 squelch held sel%0d", s));
      cyc(DIV + 1);
      chk(rxd, 1'b0, $sformatf("R5 squelch end sel%0d", s));
    end
    bell = 1'b0; tsel = 2'd0; cyc(2);

    // R5 / R6 four-wire
    four_wire = 1'b1;
    rts_n = 1'b0; cyc(3);
    chk(rxd, 1'b0, "R6 four-wire no blanking");
    rts_n = 1'b1; cyc(2);
    chk(rxd, 1'b0, "R5 four-wire no squelch");
    four_wire = 1'b0; cyc(2);

    // R4 off delay
    cd_raw_n = 1'b1;
    cyc((tk(5) - 1) * DIV);
    chk(cd_n, 1'b0, "R4 cd off early");
    cyc(DIV + 1);
    chk(cd_n, 1'b1, "R4 cd off");
    chk(rxd, 1'b1, "R6 mark without carrier");

    // R4 glitch restarts
    cd_raw_n = 1'b0; cyc(20);
    cd_raw_n = 1'b1; cyc(30);
    chk(cd_n, 1'b1, "R4 glitch ignored");

    // R7 external timers, V.23 code 3
    tsel = 2'd3; ext_cts_n = 1'b0; ext_cd_n = 1'b0; cyc(1);
    chk(cts_n, 1'b0, "R7 ext cts");
    chk(cd_n,  1'b0, "R7 ext cd");
    ext_cts_n = 1'b1; cyc(1);
    chk(cts_n, 1'b1, "R7 ext cts off");
    rts_n = 1'b0; cyc(3);
    rts_n = 1'b1; cyc(2);
    chk(rxd, 1'b0, "R7 no squelch");
    ext_cd_n = 1'b1; cyc(1);
    chk(cd_n, 1'b1, "R7 ext cd off");
    bell = 1'b1; tsel = 2'd1; ext_cts_n = 1'b0; cyc(1);
    chk(cts_n, 1'b0, "R7 bell ext cts");
    ext_cts_n = 1'b1; bell = 1'b0; tsel = 2'd0; cyc(2);

    // R8 loopback
    loop_en = 1'b1;
    txd = 1'b1; cyc(1);
    chk(rxd, 1'b1, "R8 rxd mark");
    txd = 1'b0; cyc(1);
    chk(rxd, 1'b0, "R8 rxd space");
    rts_n = 1'b0; cyc(1);
    chk(cts_n, 1'b0, "R8 cts mirror");
    chk(tx_key, 1'b0, "R8 key from secondary");
    rts2_n = 1'b0; demod = 1'b1; cyc(1);
    chk(tx_key, 1'b1, "R8 secondary keys");
    chk(tx_data, 1'b1, "R8 tx_data demod");
    rts_n = 1'b1; rts2_n = 1'b1; cyc(1);
    chk(cts_n, 1'b1, "R8 cts mirror off");
    loop_en = 1'b0; cyc(2);

    summary();
  end
endmodule